// File: doc/BRIEF.md
# Dual-Address I2C Command/Data Slave

This block is the serial front end of a buffer manager. It watches an I2C bus through an SCL input and an SDA input, both sampled from a system clock. It answers on two 7-bit addresses that play different roles. The command address accepts writes only, and every byte written to it is a command. The data address can be written, in which case each byte is handed on as write data. It can also be read, in which case the block pulls bytes from the buffer manager one at a time and shifts them out MSB first.

SDA is open-drain: the block only ever pulls the line low, through an output enable. A transaction lasts until a stop condition or a repeated start. Any number of bytes can be moved in one transaction. Addresses that match neither value are ignored until the next start. The system clock must run at least eight times faster than SCL, which allows a 1 Mbit/s bus with an 8 MHz or faster clock. The block never stretches the clock.

Top module: `i2c_dual_slave`

## Requirements
- R1: After reset, sda_oe, cmd_stb, wr_stb and rd_req are all low.
- R2: The address byte 0x36 (address 7'b0011011, RW bit 0, sent MSB first) is acknowledged: SDA is pulled low during the ninth SCL clock.
- R3: The address byte 0x37 (command address with RW=1) is not acknowledged. For the rest of that transaction SDA is never driven and rd_req never pulses.
- R4: After the command address, every following byte is acknowledged. Each one raises cmd_stb for exactly one cycle, with rx_byte holding the byte value.
- R5: After the address byte 0x34 (address 7'b0011010, RW=0), every following byte is acknowledged. Each one raises wr_stb for one cycle, with rx_byte holding the byte value.
- R6: After the address byte 0x35 (data address, RW=1) is acknowledged, rd_req pulses on the next SCL fall. rd_data is sampled one cycle after that pulse and shifted out MSB first. sda_oe changes only while SCL is low.
- R7: When the master ACKs a read byte (SDA low in the ninth clock), rd_req pulses on the following SCL fall and the next byte is sent. When the master NACKs, SDA is released and rd_req does not pulse again.
- R8: An address byte that matches neither address gets no ACK, and the bytes that follow it get no ACK and no strobes.
- R9: A repeated start (a start with no stop before it) begins a new address phase, and the new address selects the new role.
- R10: After a stop, SCL clocks that are not preceded by a start are ignored: no ACK and no strobe.
- R11: cmd_stb and wr_stb are never high together, each stays high for a single cycle, and each is raised only while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |
| rx_byte | output | 8 | Last received command or write byte |
| cmd_stb | output | 1 | One-cycle strobe: rx_byte is a command |
| wr_stb | output | 1 | One-cycle strobe: rx_byte is write data |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte, valid the cycle after rd_req |

## Verification
A bus edge reaches the control logic three cycles after it appears on a pin: two synchronizer flops plus one edge-detect register. Four results follow from that detection:
- The ACK drive and each read-data bit change one cycle after a detected SCL fall.
- cmd_stb and wr_stb rise one cycle after the eighth detected SCL rise.
- rd_req rises one cycle after the SCL fall that ends the ACK.
- The byte named by rd_data is loaded one cycle after rd_req.

The bench drives and samples only on falling clock edges. It holds each SCL phase for 20 cycles and reads SDA ten cycles into the SCL high phase, long after any of these updates has settled. Strobes and read requests are logged by a monitor on the falling edge, so a one-cycle pulse is never missed.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_ADDR,   // shifting in the address byte
    ST_HOLD,   // eight bits in, waiting for SCL fall to drive ACK
    ST_ACK,    // pulling SDA low for the ACK clock
    ST_WBIT,   // shifting in a command or write-data byte
    ST_RLOAD,  // taking the read byte from the buffer side
    ST_RBIT,   // shifting out a read byte
    ST_RACK    // sampling the master's ACK/NACK
  } slv_state_t;

  typedef enum logic [1:0] {
    MD_NONE,
    MD_CMD,
    MD_WR,
    MD_RD
  } slv_mode_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_p;
  assign scl_fall  = ~scl_s &  scl_p;
  assign bus_start =  scl_s &  scl_p &  sda_p & ~sda_s;
  assign bus_stop  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import i2c_dual_pkg::*;
#(
  parameter int              ADDR_W    = 7,
  parameter int              BYTE_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 7'b0011011,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 7'b0011010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              cmd_stb,
  output logic              wr_stb,
  output logic              rd_req
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  slv_state_t        st_q, st_n;
  slv_mode_t         md_q, md_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] byte_q, byte_n;
  logic              oe_q, oe_n;
  logic              mack_q, mack_n;
  logic              cstb_q, cstb_n;
  logic              wstb_q, wstb_n;
  logic              rreq_q, rreq_n;

  function automatic slv_mode_t decode_addr(input logic [ADDR_W-1:0] a, input logic rw);
    slv_mode_t m;
    m = MD_NONE;
    if (a == CMD_ADDR && !rw)  m = MD_CMD;
    if (a == DATA_ADDR && !rw) m = MD_WR;
    if (a == DATA_ADDR && rw)  m = MD_RD;
    return m;
  endfunction

  always_comb begin
    st_n   = st_q;
    md_n   = md_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    byte_n = byte_q;
    oe_n   = oe_q;
    mack_n = mack_q;
    cstb_n = 1'b0;
    wstb_n = 1'b0;
    rreq_n = 1'b0;
    if (bus_stop) begin
      st_n = ST_IDLE;
      md_n = MD_NONE;
      oe_n = 1'b0;
    end else if (bus_start) begin
      st_n  = ST_ADDR;
      md_n  = MD_NONE;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              md_n  = decode_addr(sh_q[ADDR_W-1:0], sda_s);
              cnt_n = '0;
              st_n  = ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (scl_fall) begin
            if (md_q != MD_NONE) begin
              oe_n = 1'b1;
              st_n = ST_ACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_n = 1'b0;
            if (md_q == MD_RD) begin
              rreq_n = 1'b1;
              st_n   = ST_RLOAD;
            end else begin
              cnt_n = '0;
              st_n  = ST_WBIT;
            end
          end
        end
        ST_WBIT: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              byte_n = {sh_q[BYTE_W-2:0], sda_s};
              cstb_n = (md_q == MD_CMD);
              wstb_n = (md_q == MD_WR);
              cnt_n  = '0;
              st_n   = ST_HOLD;
            end
          end
        end
        ST_RLOAD: begin
          sh_n  = rd_data;
          oe_n  = ~rd_data[BYTE_W-1];
          cnt_n = '0;
          st_n  = ST_RBIT;
        end
        ST_RBIT: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n  = ~sh_q[BYTE_W-2];
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end
          if (scl_fall) begin
            if (mack_q) begin
              rreq_n = 1'b1;
              st_n   = ST_RLOAD;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      md_q   <= MD_NONE;
      cnt_q  <= '0;
      sh_q   <= '0;
      byte_q <= '0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
      cstb_q <= 1'b0;
      wstb_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      md_q   <= md_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      byte_q <= byte_n;
      oe_q   <= oe_n;
      mack_q <= mack_n;
      cstb_q <= cstb_n;
      wstb_q <= wstb_n;
      rreq_q <= rreq_n;
    end
  end

  assign sda_oe  = oe_q;
  assign rx_byte = byte_q;
  assign cmd_stb = cstb_q;
  assign wr_stb  = wstb_q;
  assign rd_req  = rreq_q;

endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave #(
  parameter int              ADDR_W      = 7,
  parameter int              BYTE_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 7'b0011011,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 7'b0011010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              cmd_stb,
  output logic              wr_stb,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data
);

  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [1:0] line_raw, line_s;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  assign line_raw[IDX_SCL] = scl_i;
  assign line_raw[IDX_SDA] = sda_i;

  i2c_line_sync #(
    .LINES  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_raw),
    .q     (line_s)
  );

  i2c_bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (line_s[IDX_SCL]),
    .sda_s     (line_s[IDX_SDA]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2c_slave_core #(
    .ADDR_W    (ADDR_W),
    .BYTE_W    (BYTE_W),
    .CMD_ADDR  (CMD_ADDR),
    .DATA_ADDR (DATA_ADDR)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (line_s[IDX_SDA]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .rx_byte   (rx_byte),
    .cmd_stb   (cmd_stb),
    .wr_stb    (wr_stb),
    .rd_req    (rd_req)
  );

endmodule

// File: rtl/i2c_dual_slave_chk.sv
module i2c_dual_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic cmd_stb,
  input logic wr_stb,
  input logic rd_req
);

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i); // R6

  AST_RDREQ_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !scl_i); // R7

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && wr_stb)); // R11

  AST_CMD_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb); // R11

  AST_WR_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R11

  AST_STB_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb || wr_stb) |-> scl_i); // R11

endmodule

bind i2c_dual_slave i2c_dual_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe),
  .cmd_stb (cmd_stb),
  .wr_stb  (wr_stb),
  .rd_req  (rd_req)
);

// File: tb/sim_i2c_dual_slave.sv
module sim_i2c_dual_slave;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 20;
  localparam int Q          = 5;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, cmd_stb, wr_stb, rd_req;
  logic [7:0] rx_byte;
  logic [7:0] rd_val = 8'h00;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dual_slave u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .sda_oe  (sda_oe),
    .rx_byte (rx_byte),
    .cmd_stb (cmd_stb),
    .wr_stb  (wr_stb),
    .rd_req  (rd_req),
    .rd_data (rd_val)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [7:0] cmd_log [0:255];
  logic [7:0] wr_log  [0:255];
  logic [7:0] rd_q    [0:255];
  int cmd_n = 0, wr_n = 0, rd_idx = 0;
  int oe_viol = 0, stb_viol = 0;
  logic oe_prev = 1'b0, cs_prev = 1'b0, ws_prev = 1'b0;

  // negedge monitor: logs strobes, serves read bytes, watches framing
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_stb) begin cmd_log[cmd_n[7:0]] = rx_byte; cmd_n++; end
      if (wr_stb)  begin wr_log[wr_n[7:0]]   = rx_byte; wr_n++;  end
      if (rd_req)  begin rd_val = rd_q[rd_idx[7:0]]; rd_idx++; end
      if (sda_oe != oe_prev && scl_m) oe_viol++;
      if ((cmd_stb && wr_stb) || (cmd_stb && cs_prev) || (wr_stb && ws_prev)) stb_viol++;
      if ((cmd_stb || wr_stb) && !scl_m) stb_viol++;
    end
    oe_prev = sda_oe;
    cs_prev = cmd_stb;
    ws_prev = wr_stb;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    wclk(Q); sda_m = 1'b1; wclk(H-Q); scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H); scl_m = 1'b0;
  endtask

  task automatic m_stop();
    wclk(Q); sda_m = 1'b0; wclk(H-Q); scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic m_write(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      wclk(Q); sda_m = b[i]; wclk(H-Q); scl_m = 1'b1; wclk(H); scl_m = 1'b0;
    end
    wclk(Q); sda_m = 1'b1; wclk(H-Q); scl_m = 1'b1; wclk(H/2);
    acked = (sda_bus == 1'b0);
    wclk(H-H/2); scl_m = 1'b0;
  endtask

  task automatic m_read(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(H); scl_m = 1'b1; wclk(H/2); b[i] = sda_bus; wclk(H-H/2); scl_m = 1'b0;
    end
    wclk(Q); sda_m = ~give_ack; wclk(H-Q); scl_m = 1'b1; wclk(H); scl_m = 1'b0;
    wclk(Q); sda_m = 1'b1;
  endtask

  // expected-value helpers
  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  function automatic logic expect_ack(input logic [7:0] ab);
    return (ab == 8'h36) || (ab == 8'h34) || (ab == 8'h35);
  endfunction

  task automatic do_cmd_write(input int nb, input string tag);
    logic ack; logic [7:0] b; int base;
    base = cmd_n;
    m_start();
    m_write(addr_byte(7'b0011011, 1'b0), ack);
    chk({tag, " R2 command address ACK"}, ack, 1);
    for (int k = 0; k < nb; k++) begin
      b = 8'($urandom);
      m_write(b, ack);
      chk({tag, " R4 command byte ACK"}, ack, 1);
      wclk(2);
      chk({tag, " R4 command byte value"}, cmd_log[(base+k) & 255], b);
    end
    chk({tag, " R4 command strobe count"}, cmd_n - base, nb);
    m_stop();
  endtask

  task automatic do_data_write(input int nb, input string tag);
    logic ack; logic [7:0] b; int base;
    base = wr_n;
    m_start();
    m_write(addr_byte(7'b0011010, 1'b0), ack);
    chk({tag, " R5 data write address ACK"}, ack, 1);
    for (int k = 0; k < nb; k++) begin
      b = 8'($urandom);
      m_write(b, ack);
      chk({tag, " R5 write byte ACK"}, ack, 1);
      wclk(2);
      chk({tag, " R5 write byte value"}, wr_log[(base+k) & 255], b);
    end
    chk({tag, " R5 write strobe count"}, wr_n - base, nb);
    m_stop();
  endtask

  task automatic do_data_read(input int nb, input string tag);
    logic ack; logic [7:0] b; int base;
    base = rd_idx;
    for (int k = 0; k < nb; k++) rd_q[(base+k) & 255] = 8'($urandom);
    m_start();
    m_write(addr_byte(7'b0011010, 1'b1), ack);
    chk({tag, " R6 data read address ACK"}, ack, 1);
    for (int k = 0; k < nb; k++) begin
      m_read(b, k != nb-1);
      chk({tag, " R6 read byte MSB first"}, b, rd_q[(base+k) & 255]);
    end
    wclk(H);
    chk({tag, " R7 SDA released after NACK"}, sda_oe, 0);
    chk({tag, " R7 read request count"}, rd_idx - base, nb);
    m_stop();
  endtask

  initial begin
    logic ack; logic [7:0] b; int c0, w0, r0;
    void'($urandom(32'd1234));
    wclk(3);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset cmd_stb", cmd_stb, 0);
    chk("R1 reset wr_stb", wr_stb, 0);
    chk("R1 reset rd_req", rd_req, 0);
    rst_n = 1'b1;
    wclk(10);

    // directed corner cases
    do_cmd_write(3, "dir");
    do_data_write(4, "dir");
    do_data_read(3, "dir");
    do_data_read(1, "dir single");

    // R3: read on command address
    r0 = rd_idx;
    m_start();
    m_write(8'h37, ack);
    chk("R3 command address read NACK", ack, 0);
    m_read(b, 1'b0);
    chk("R3 no drive after refused read", b, 8'hFF);
    chk("R3 no read request", rd_idx - r0, 0);
    m_stop();

    // R8: unmatched address
    c0 = cmd_n; w0 = wr_n;
    m_start();
    m_write(8'h50, ack);
    chk("R8 unmatched address NACK", ack, 0);
    m_write(8'hA5, ack);
    chk("R8 byte after unmatched NACK", ack, 0);
    m_write(8'h00, ack);
    chk("R8 second byte NACK", ack, 0);
    chk("R8 no command strobe", cmd_n - c0, 0);
    chk("R8 no write strobe", wr_n - w0, 0);
    m_stop();

    // R9: repeated start switches role
    c0 = cmd_n; w0 = wr_n;
    m_start();
    m_write(8'h36, ack);
    chk("R9 first address ACK", ack, 1);
    m_write(8'h5A, ack);
    m_start();
    m_write(8'h34, ack);
    chk("R9 address after repeated start ACK", ack, 1);
    m_write(8'hC3, ack);
    wclk(2);
    chk("R9 command count", cmd_n - c0, 1);
    chk("R9 write count", wr_n - w0, 1);
    chk("R9 command byte", cmd_log[c0 & 255], 8'h5A);
    chk("R9 write byte", wr_log[w0 & 255], 8'hC3);
    m_stop();

    // R10: clocks without a start after stop
    c0 = cmd_n; w0 = wr_n;
    wclk(H); scl_m = 1'b0;
    m_write(8'h36, ack);
    chk("R10 no ACK without start", ack, 0);
    m_write(8'h11, ack);
    chk("R10 no ACK on later byte", ack, 0);
    chk("R10 no strobes", (cmd_n - c0) + (wr_n - w0), 0);
    m_stop();

    // constrained random transactions
    for (int t = 0; t < 10; t++) begin
      int kind, nb;
      kind = $urandom_range(3, 0);
      nb   = $urandom_range(4, 1);
      case (kind)
        0: do_cmd_write(nb, "rnd");
        1: do_data_write(nb, "rnd");
        2: do_data_read(nb, "rnd");
        default: begin
          b = 8'($urandom);
          m_start();
          m_write(b, ack);
          chk("rnd R8 address decode", ack, expect_ack(b));
          if (ack) begin
            if (b[0]) begin
              rd_q[rd_idx & 255] = 8'h00;
              m_read(b, 1'b0);
            end else m_write(8'h00, ack);
          end
          m_stop();
        end
      endcase
    end

    chk("R6 sda_oe changed while SCL high", oe_viol, 0);
    chk("R11 strobe framing violations", stb_viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule